// File: doc/BRIEF.md
# Clock-Slave Synchronous Serial Shifter

This block is a full-duplex synchronous serial port that runs from a serial clock supplied by a remote master. The serial clock and receive line are brought into the system clock domain through a two-stage synchroniser, and an edge detector turns them into one-cycle rise and fall events. Each frame is 8 bits, least significant bit first. Transmit bits change on the falling edge and receive bits are sampled on the rising edge, so both directions move together.

The host loads a transmit buffer and reads a receive buffer. The receive side always has a shift register plus a separate buffer. The transmit side runs in one of two modes, chosen by an enable input. In single mode the buffer is copied into the shifter at the first falling edge of a frame. In double mode the copy also happens at the end of a frame, so the next byte is already staged. Overrun and underrun are latched as sticky flags and are cleared by writing ones. On underrun, the transmit pin drives a level chosen by the host for the whole frame.

Top module: `sio_slave_shifter`

## Requirements
- R1: While rst_ni is low, both buffers read empty, ovr_o, udr_o, tx_irq_o and rx_irq_o are 0, and txd_o equals idle_lvl_i.
- R2: A byte taken from the transmit buffer appears on txd_o bit 0 first. Each bit is presented after a falling serial clock edge and held through the following rising edge.
- R3: rxd_i is sampled on each rising serial clock edge, bit 0 first. After the eighth rising edge the byte moves into rx_data_o, rx_full_o is set, and rx_irq_o pulses for one cycle. rx_data_o changes at no other time.
- R4: A tx_wr_i pulse sets tx_full_o. An rx_rd_i pulse clears rx_full_o.
- R5: With dbuf_en_i = 0, tx_irq_o pulses once at the end of each frame. A buffered byte stays in the transmit buffer (tx_full_o stays 1) until the first falling edge of the next frame.
- R6: With dbuf_en_i = 1, a byte waiting in the transmit buffer at the end of a frame moves into the shifter in the same cycle as the receive transfer. tx_full_o clears, tx_irq_o pulses together with rx_irq_o, and that byte is sent in the next frame without underrun.
- R7: If rx_full_o is still 1 when the eighth bit of a new frame arrives, ovr_o is set. The old buffer contents are kept, the new byte is dropped, and rx_irq_o does not pulse.
- R8: If neither the shifter nor the buffer holds a byte at the first falling edge of a frame, udr_o is set and txd_o holds idle_lvl_i for the whole frame.
- R9: A byte written after the first falling edge of a frame is not sent in that frame. It is sent in the following frame.
- R10: err_clr_i is write-one-to-clear: bit 0 clears ovr_o and bit 1 clears udr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | External serial clock, idles high |
| rxd_i | input | 1 | Serial receive data |
| txd_o | output | 1 | Serial transmit data |
| dbuf_en_i | input | 1 | Transmit double-buffer enable |
| idle_lvl_i | input | 1 | Level driven on txd_o when no byte is being sent |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | 8 | Transmit buffer write data |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | 8 | Receive buffer contents |
| tx_full_o | output | 1 | Transmit buffer holds an unsent byte |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| err_clr_i | input | 2 | Flag clear, bit 0 overrun, bit 1 underrun |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| ovr_o | output | 1 | Sticky overrun flag |
| udr_o | output | 1 | Sticky underrun flag |

## Verification
A bit counter that drifts from the serial clock shows up within one frame: txd_o carries a rotated byte, and the receive pulse or byte lands at the wrong point. A wrong shifter-valid state shows up as a spurious or missing underrun, or as idle-level bits, at the next frame start. A wrong buffer-full state shows up in tx_full_o, or as a lost or kept byte on overrun, no later than the end of the following frame. The bench runs single and double transmit modes, both idle levels, late writes and an unread receive buffer, and compares every byte against queued expectations.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned DEF_FRAME_W = 8;
  localparam int unsigned DEF_SYNC_N  = 2;
  localparam int unsigned ERR_OVR_BIT = 0;
  localparam int unsigned ERR_UDR_BIT = 1;

  typedef struct packed {
    logic rise;
    logic fall;
    logic rxd;
  } sclk_ev_t;
endpackage

// File: rtl/sio_sync_edge.sv
module sio_sync_edge
  import sio_pkg::*;
#(
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_i,
  input  logic     rxd_i,
  output sclk_ev_t ev_o
);
  logic [SYNC_N-1:0] sclk_q, rxd_q;
  logic              sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= '1;
      rxd_q       <= '1;
      sclk_prev_q <= 1'b1;
    end else begin
      sclk_q      <= {sclk_q[SYNC_N-2:0], sclk_i};
      rxd_q       <= {rxd_q[SYNC_N-2:0], rxd_i};
      sclk_prev_q <= sclk_q[SYNC_N-1];
    end
  end

  // rxd goes through the same depth as sclk so the sample stays aligned
  assign ev_o.rise = sclk_q[SYNC_N-1] & ~sclk_prev_q;
  assign ev_o.fall = ~sclk_q[SYNC_N-1] & sclk_prev_q;
  assign ev_o.rxd  = rxd_q[SYNC_N-1];
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core
  import sio_pkg::*;
#(
  parameter int unsigned FRAME_W = DEF_FRAME_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sclk_ev_t           ev_i,
  input  logic               idle_lvl_i,
  input  logic               load_en_i,
  input  logic [FRAME_W-1:0] load_data_i,
  output logic               frame_start_o,
  output logic               frame_end_o,
  output logic               sh_valid_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               txd_o
);
  localparam int unsigned CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q;
  logic               sh_valid_q;

  assign frame_start_o = ev_i.fall & ~active_q;
  assign frame_end_o   = ev_i.rise & active_q & (cnt_q == LAST_BIT);
  assign rx_word_o     = {ev_i.rxd, rx_sh_q[FRAME_W-1:1]};
  assign sh_valid_o    = sh_valid_q;
  assign txd_o         = (active_q & sh_valid_q) ? tx_sh_q[0] : idle_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      sh_valid_q <= 1'b0;
    end else begin
      if (ev_i.fall) begin
        if (!active_q) begin
          active_q <= 1'b1;
          cnt_q    <= '0;
        end else begin
          tx_sh_q  <= tx_sh_q >> 1;
        end
      end
      if (ev_i.rise && active_q) begin
        rx_sh_q <= rx_word_o;
        if (cnt_q == LAST_BIT) begin
          active_q   <= 1'b0;
          cnt_q      <= '0;
          sh_valid_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (load_en_i) begin
        tx_sh_q    <= load_data_i;
        sh_valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_buf_ctrl.sv
module sio_buf_ctrl
  import sio_pkg::*;
#(
  parameter int unsigned FRAME_W = DEF_FRAME_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dbuf_en_i,
  input  logic               tx_wr_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               rx_rd_i,
  input  logic [1:0]         err_clr_i,
  input  logic               frame_start_i,
  input  logic               frame_end_i,
  input  logic               sh_valid_i,
  input  logic [FRAME_W-1:0] rx_word_i,
  output logic               load_en_o,
  output logic [FRAME_W-1:0] load_data_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               tx_full_o,
  output logic               rx_full_o,
  output logic               tx_irq_o,
  output logic               rx_irq_o,
  output logic               ovr_o,
  output logic               udr_o
);
  logic [FRAME_W-1:0] tx_buf_q, rx_buf_q;
  logic tx_full_q, rx_full_q, tx_irq_q, rx_irq_q, ovr_q, udr_q;
  logic load_start, load_end, udr_set, ovr_set, rx_take;

  assign load_start = frame_start_i & ~sh_valid_i & tx_full_q;
  assign load_end   = frame_end_i & dbuf_en_i & tx_full_q;
  assign load_en_o  = load_start | load_end;
  assign load_data_o = tx_buf_q;
  assign udr_set    = frame_start_i & ~sh_valid_i & ~tx_full_q;
  assign ovr_set    = frame_end_i & rx_full_q;
  assign rx_take    = frame_end_i & ~rx_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q  <= '0;
      rx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      tx_irq_q  <= 1'b0;
      rx_irq_q  <= 1'b0;
      ovr_q     <= 1'b0;
      udr_q     <= 1'b0;
    end else begin
      if (tx_wr_i) begin
        tx_buf_q  <= tx_data_i;
        tx_full_q <= 1'b1;
      end else if (load_en_o) begin
        tx_full_q <= 1'b0;
      end
      if (rx_take) begin
        rx_buf_q  <= rx_word_i;
        rx_full_q <= 1'b1;
      end else if (rx_rd_i) begin
        rx_full_q <= 1'b0;
      end
      tx_irq_q <= dbuf_en_i ? load_en_o : frame_end_i;
      rx_irq_q <= rx_take;
      ovr_q    <= ovr_set | (ovr_q & ~err_clr_i[ERR_OVR_BIT]);
      udr_q    <= udr_set | (udr_q & ~err_clr_i[ERR_UDR_BIT]);
    end
  end

  assign rx_data_o = rx_buf_q;
  assign tx_full_o = tx_full_q;
  assign rx_full_o = rx_full_q;
  assign tx_irq_o  = tx_irq_q;
  assign rx_irq_o  = rx_irq_q;
  assign ovr_o     = ovr_q;
  assign udr_o     = udr_q;
endmodule

// File: rtl/sio_slave_shifter.sv
module sio_slave_shifter
  import sio_pkg::*;
#(
  parameter int unsigned FRAME_W = DEF_FRAME_W,
  parameter int unsigned SYNC_N  = DEF_SYNC_N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               rxd_i,
  output logic               txd_o,
  input  logic               dbuf_en_i,
  input  logic               idle_lvl_i,
  input  logic               tx_wr_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               rx_rd_i,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               tx_full_o,
  output logic               rx_full_o,
  input  logic [1:0]         err_clr_i,
  output logic               tx_irq_o,
  output logic               rx_irq_o,
  output logic               ovr_o,
  output logic               udr_o
);
  sclk_ev_t           ev;
  logic               frame_start, frame_end, sh_valid, load_en;
  logic [FRAME_W-1:0] rx_word, load_data;

  sio_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rxd_i  (rxd_i),
    .ev_o   (ev)
  );

  sio_shift_core #(.FRAME_W(FRAME_W)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ev_i          (ev),
    .idle_lvl_i    (idle_lvl_i),
    .load_en_i     (load_en),
    .load_data_i   (load_data),
    .frame_start_o (frame_start),
    .frame_end_o   (frame_end),
    .sh_valid_o    (sh_valid),
    .rx_word_o     (rx_word),
    .txd_o         (txd_o)
  );

  sio_buf_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dbuf_en_i     (dbuf_en_i),
    .tx_wr_i       (tx_wr_i),
    .tx_data_i     (tx_data_i),
    .rx_rd_i       (rx_rd_i),
    .err_clr_i     (err_clr_i),
    .frame_start_i (frame_start),
    .frame_end_i   (frame_end),
    .sh_valid_i    (sh_valid),
    .rx_word_i     (rx_word),
    .load_en_o     (load_en),
    .load_data_o   (load_data),
    .rx_data_o     (rx_data_o),
    .tx_full_o     (tx_full_o),
    .rx_full_o     (rx_full_o),
    .tx_irq_o      (tx_irq_o),
    .rx_irq_o      (rx_irq_o),
    .ovr_o         (ovr_o),
    .udr_o         (udr_o)
  );
endmodule

// File: rtl/sio_slave_shifter_chk.sv
module sio_slave_shifter_chk #(
  parameter int unsigned FRAME_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tx_wr_i,
  input logic [1:0]         err_clr_i,
  input logic [FRAME_W-1:0] rx_data_o,
  input logic               tx_full_o,
  input logic               rx_full_o,
  input logic               tx_irq_o,
  input logic               rx_irq_o,
  input logic               ovr_o,
  input logic               udr_o
);
  p_rx_irq_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_full_o);

  p_rx_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_irq_o |-> $stable(rx_data_o));

  p_tx_full_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_full_o) |-> $past(tx_wr_i));

  p_tx_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);

  p_ovr_needs_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($past(rx_full_o) && $stable(rx_data_o) && !rx_irq_o));

  p_udr_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(udr_o)) |-> $past(err_clr_i[1]));
endmodule

bind sio_slave_shifter sio_slave_shifter_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_wr_i   (tx_wr_i),
  .err_clr_i (err_clr_i),
  .rx_data_o (rx_data_o),
  .tx_full_o (tx_full_o),
  .rx_full_o (rx_full_o),
  .tx_irq_o  (tx_irq_o),
  .rx_irq_o  (rx_irq_o),
  .ovr_o     (ovr_o),
  .udr_o     (udr_o)
);

// File: tb/tb_sio_slave_shifter.sv
`timescale 1ns/1ps
module tb_sio_slave_shifter;
  localparam int HALF = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b1, rxd_i = 1'b1;
  logic       dbuf_en_i = 1'b0, idle_lvl_i = 1'b1;
  logic       tx_wr_i = 1'b0, rx_rd_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic [1:0] err_clr_i = '0;
  logic       txd_o, tx_full_o, rx_full_o, tx_irq_o, rx_irq_o, ovr_o, udr_o;
  logic [7:0] rx_data_o;

  int checks = 0, fails = 0;
  int tx_irq_cnt = 0, both_cnt = 0;
  bit done = 0;
  logic [7:0] exp_rx_q[$];
  logic [7:0] exp_tx_q[$];

  always #10 clk_i = ~clk_i;

  sio_slave_shifter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .rxd_i(rxd_i), .txd_o(txd_o),
    .dbuf_en_i(dbuf_en_i), .idle_lvl_i(idle_lvl_i), .tx_wr_i(tx_wr_i),
    .tx_data_i(tx_data_i), .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o),
    .tx_full_o(tx_full_o), .rx_full_o(rx_full_o), .err_clr_i(err_clr_i),
    .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o), .ovr_o(ovr_o), .udr_o(udr_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: receive scoreboard and interrupt bookkeeping
  always @(negedge clk_i) begin
    if (rst_ni && tx_irq_o) tx_irq_cnt++;
    if (rst_ni && rx_irq_o) begin
      if (tx_irq_o) both_cnt++;
      if (exp_rx_q.size() == 0) chk("R7 unexpected rx_irq", 1, 0);
      else chk("R3 rx byte", int'(rx_data_o), int'(exp_rx_q.pop_front()));
    end
  end

  task automatic wr_tx(input logic [7:0] d);
    @(negedge clk_i); tx_wr_i = 1'b1; tx_data_i = d;
    @(negedge clk_i); tx_wr_i = 1'b0;
  endtask

  task automatic rd_rx();
    @(negedge clk_i); rx_rd_i = 1'b1;
    @(negedge clk_i); rx_rd_i = 1'b0;
  endtask

  task automatic clr_err(input logic [1:0] m);
    @(negedge clk_i); err_clr_i = m;
    @(negedge clk_i); err_clr_i = '0;
    @(negedge clk_i);
  endtask

  // driver: one master frame; pushes expectations, captures txd
  task automatic frame(input logic [7:0] rxb, input logic [7:0] exp_tx,
                       input bit push_rx, input bit late, input logic [7:0] late_d);
    logic [7:0] got;
    if (push_rx) exp_rx_q.push_back(rxb);
    exp_tx_q.push_back(exp_tx);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      sclk_i = 1'b0; rxd_i = rxb[i];
      if (late && i == 2) begin tx_wr_i = 1'b1; tx_data_i = late_d; end
      @(negedge clk_i);
      tx_wr_i = 1'b0;
      repeat (HALF - 1) @(negedge clk_i);
      got[i] = txd_o;
      sclk_i = 1'b1;
      repeat (HALF - 1) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    chk("R2 tx byte", int'(got), int'(exp_tx_q.pop_front()));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk_i);
    chk("R1 txd idle", txd_o, 1);
    chk("R1 tx_full", tx_full_o, 0);
    chk("R1 rx_full", rx_full_o, 0);
    chk("R1 flags", {ovr_o, udr_o, tx_irq_o, rx_irq_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // single buffer, normal traffic
    wr_tx(8'hA5);
    chk("R4 tx_full set", tx_full_o, 1);
    base = tx_irq_cnt;
    frame(8'h3C, 8'hA5, 1, 0, 8'h00);
    chk("R5 one tx_irq per frame", tx_irq_cnt - base, 1);
    chk("R3 rx_full after frame", rx_full_o, 1);
    rd_rx();
    chk("R4 rx_full cleared", rx_full_o, 0);
    wr_tx(8'h5A);
    frame(8'hC3, 8'h5A, 1, 0, 8'h00);
    chk("R8 no underrun", udr_o, 0);
    rd_rx();

    // underrun with late write, idle high
    frame(8'h81, 8'hFF, 1, 1, 8'h96);
    chk("R8 underrun flag", udr_o, 1);
    chk("R5 single mode keeps buffer", tx_full_o, 1);
    rd_rx();
    frame(8'h7E, 8'h96, 1, 0, 8'h00);
    chk("R9 late byte sent next frame", tx_full_o, 0);
    rd_rx();
    clr_err(2'b10);
    chk("R10 udr cleared", udr_o, 0);

    // underrun with idle low
    idle_lvl_i = 1'b0;
    @(negedge clk_i);
    chk("R8 idle low between frames", txd_o, 0);
    frame(8'h0F, 8'h00, 1, 0, 8'h00);
    chk("R8 underrun idle low", udr_o, 1);
    rd_rx();
    clr_err(2'b10);
    idle_lvl_i = 1'b1;

    // overrun
    wr_tx(8'h11);
    frame(8'h22, 8'h11, 1, 0, 8'h00);
    wr_tx(8'h33);
    frame(8'h44, 8'h33, 0, 0, 8'h00);
    chk("R7 overrun flag", ovr_o, 1);
    chk("R7 old data kept", int'(rx_data_o), 8'h22);
    chk("R7 rx_full held", rx_full_o, 1);
    clr_err(2'b01);
    chk("R10 ovr cleared", ovr_o, 0);
    rd_rx();

    // double buffer mode
    dbuf_en_i = 1'b1;
    wr_tx(8'h77);
    base = both_cnt;
    frame(8'h88, 8'h77, 1, 1, 8'hE1);
    chk("R6 buffer drained at frame end", tx_full_o, 0);
    chk("R6 tx_irq with rx_irq", both_cnt - base, 1);
    rd_rx();
    frame(8'h5C, 8'hE1, 1, 0, 8'h00);
    chk("R6 staged byte no underrun", udr_o, 0);
    rd_rx();
    chk("R3 all rx consumed", exp_rx_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule